// File: doc/BRIEF.md
# Radix-2 Single-Delay-Feedback FFT Stage

This block is one stage of a streaming, decimation-in-frequency FFT pipeline. Each cycle it may accept one complex fixed-point sample, qualified by a valid strobe, and it emits at most one complex sample to the next stage one cycle later. A feedback shift register of `DEPTH` entries holds half of the current sub-block. A single radix-2 add/subtract butterfly pairs each stored sample with the sample arriving `DEPTH` accepted samples later. The stage accepts input on every cycle, so a sample is taken in the same cycle that its valid strobe is high.

An N-point transform chains log2(N) of these stages, with `DEPTH` set to N/2, N/4, down to 1. Every second stage is built with `MODIFIED` set. That variant rotates the incoming operand by -j, by swapping its parts and negating one of them, during the last quarter of each 4·DEPTH-sample period. Two cascaded stages therefore need no complex multiplier between them. A general twiddle multiplication sits outside the block, between stage pairs. The chained pipeline delivers the transform scaled by 1/N, in bit-reversed index order.

Top module: `sdf_r2_stage`

## Requirements
- R1: In the fill phase, which is the first DEPTH accepted samples of each 2·DEPTH-sample period counted from reset, the input is written unchanged into the delay line. In the same cycle the oldest delay-line entry is presented at the output.
- R2: In the compute phase, which is the next DEPTH accepted samples, the output is the scaled sum of the delay-line head (a) and the current operand (b).
- R3: In the compute phase, the scaled difference a-b is written into the delay line. It leaves the stage as output during the following fill phase, DEPTH accepted samples later.
- R4: Each butterfly result v is scaled as floor((v+1)/2), which rounds half up. It is then saturated to the signed DATA_W range [-2^(DATA_W-1), 2^(DATA_W-1)-1].
- R5: With MODIFIED=1, during the last DEPTH accepted samples of each 4·DEPTH-sample period, the operand b=(re,im) is replaced by (im, -re) before the butterfly. With MODIFIED=0 the operand is never altered.
- R6: out_valid_o is high for exactly one cycle after each accepted sample, except the first DEPTH accepted samples after reset. A cycle with in_valid_i low changes nothing: the phase counter, the delay line and the output data all hold. In that cycle out_valid_o is driven low.
- R7: While rst_ni is low, the phase counter, the delay line and both output data ports are zero, and out_valid_o is low.
- R8: Four stages with DEPTH 8, 4, 2, 1 and MODIFIED 0, 1, 0, 1 can be chained with a twiddle multiplier after the second stage. The chain produces the 16-point DFT divided by 16, with output position P holding bin bitrev4(P).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input sample valid |
| in_re_i | input | DATA_W | Input real part, signed |
| in_im_i | input | DATA_W | Input imaginary part, signed |
| out_valid_o | output | 1 | Output sample valid |
| out_re_o | output | DATA_W | Output real part, signed |
| out_im_o | output | DATA_W | Output imaginary part, signed |

## Verification
The hardest case to reach from the ports is the rotated operand at full scale. The -j swap and negate must both saturate, and those saturated results must come back out of the delay line one fill phase later. The stimulus table places extreme values at the exact positions in the 4·DEPTH period where rotation applies and where the difference is drained. The same table is replayed with an idle cycle after every sample, to show that stalls hold all state. A four-stage chain with valid gaps then checks the full bit-reversed transform against a DFT computed in the bench.

// File: rtl/sdf_pkg.sv
package sdf_pkg;
  typedef enum logic {
    PH_FILL = 1'b0,
    PH_CALC = 1'b1
  } sdf_phase_e;
endpackage

// File: rtl/sdf_phase_ctrl.sv
module sdf_phase_ctrl
  import sdf_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       adv_i,
  output sdf_phase_e phase_o,
  output logic       rot_zone_o,
  output logic       primed_o
);
  localparam int LOG_D = $clog2(DEPTH);
  localparam int CNT_W = LOG_D + 2;

  logic [CNT_W-1:0] cnt_q;
  logic             primed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      primed_q <= 1'b0;
    end else if (adv_i) begin
      cnt_q <= cnt_q + 1'b1;
      if (phase_o == PH_CALC) primed_q <= 1'b1;
    end
  end

  assign phase_o    = sdf_phase_e'(cnt_q[LOG_D]);
  assign rot_zone_o = cnt_q[LOG_D+1] & cnt_q[LOG_D];
  assign primed_o   = primed_q;

  p_cnt_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(cnt_q));
  p_primed_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed_q |=> primed_q);
endmodule

// File: rtl/sdf_delay_line.sv
module sdf_delay_line #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             shift_i,
  input  logic [WIDTH-1:0] din_i,
  output logic [WIDTH-1:0] dout_o
);
  logic [WIDTH-1:0] tap_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tap_q[0] <= '0;
    else if (shift_i) tap_q[0] <= din_i;
  end

  for (genvar i = 1; i < DEPTH; i++) begin : g_tap
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) tap_q[i] <= '0;
      else if (shift_i) tap_q[i] <= tap_q[i-1];
    end
  end

  assign dout_o = tap_q[DEPTH-1];

  p_dl_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_i |=> $stable(dout_o));
endmodule

// File: rtl/sdf_butterfly.sv
module sdf_butterfly #(
  parameter int DATA_W   = 16,
  parameter bit MODIFIED = 1'b0
) (
  input  logic signed [DATA_W-1:0] a_re_i,
  input  logic signed [DATA_W-1:0] a_im_i,
  input  logic signed [DATA_W-1:0] b_re_i,
  input  logic signed [DATA_W-1:0] b_im_i,
  input  logic                     rot_i,
  output logic signed [DATA_W-1:0] sum_re_o,
  output logic signed [DATA_W-1:0] sum_im_o,
  output logic signed [DATA_W-1:0] dif_re_o,
  output logic signed [DATA_W-1:0] dif_im_o,
  output logic                     sat_o
);
  localparam int EW = DATA_W + 2;
  localparam logic signed [EW-1:0] MAX_V = EW'((2 ** (DATA_W - 1)) - 1);
  localparam logic signed [EW-1:0] MIN_V = -EW'(2 ** (DATA_W - 1));

  logic signed [EW-1:0] a_re_x, a_im_x, b_re_x, b_im_x, op_re, op_im;
  logic signed [EW-1:0] h_sr, h_si, h_dr, h_di;

  assign a_re_x = EW'(a_re_i);
  assign a_im_x = EW'(a_im_i);
  assign b_re_x = EW'(b_re_i);
  assign b_im_x = EW'(b_im_i);

  // -j * (re + j im) = im - j re
  if (MODIFIED) begin : g_rot
    assign op_re = rot_i ? b_im_x : b_re_x;
    assign op_im = rot_i ? -b_re_x : b_im_x;
  end else begin : g_plain
    logic unused_rot;
    assign unused_rot = rot_i;
    assign op_re = b_re_x;
    assign op_im = b_im_x;
  end

  assign h_sr = (a_re_x + op_re + EW'(1)) >>> 1;
  assign h_si = (a_im_x + op_im + EW'(1)) >>> 1;
  assign h_dr = (a_re_x - op_re + EW'(1)) >>> 1;
  assign h_di = (a_im_x - op_im + EW'(1)) >>> 1;

  function automatic logic signed [DATA_W-1:0] clip(input logic signed [EW-1:0] v);
    if (v > MAX_V) return MAX_V[DATA_W-1:0];
    if (v < MIN_V) return MIN_V[DATA_W-1:0];
    return v[DATA_W-1:0];
  endfunction

  function automatic logic over(input logic signed [EW-1:0] v);
    return (v > MAX_V) || (v < MIN_V);
  endfunction

  assign sum_re_o = clip(h_sr);
  assign sum_im_o = clip(h_si);
  assign dif_re_o = clip(h_dr);
  assign dif_im_o = clip(h_di);
  assign sat_o    = over(h_sr) | over(h_si) | over(h_dr) | over(h_di);
endmodule

// File: rtl/sdf_r2_stage.sv
module sdf_r2_stage
  import sdf_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int DEPTH    = 8,
  parameter bit MODIFIED = 1'b0
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     in_valid_i,
  input  logic signed [DATA_W-1:0] in_re_i,
  input  logic signed [DATA_W-1:0] in_im_i,
  output logic                     out_valid_o,
  output logic signed [DATA_W-1:0] out_re_o,
  output logic signed [DATA_W-1:0] out_im_o
);
  localparam int CW = 2 * DATA_W;

  sdf_phase_e phase;
  logic       rot_zone, primed, sat;
  logic [CW-1:0] dl_din, dl_dout;
  logic signed [DATA_W-1:0] head_re, head_im;
  logic signed [DATA_W-1:0] s_re, s_im, d_re, d_im;
  logic signed [DATA_W-1:0] nxt_re, nxt_im;
  logic       calc;

  sdf_phase_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .adv_i      (in_valid_i),
    .phase_o    (phase),
    .rot_zone_o (rot_zone),
    .primed_o   (primed)
  );

  sdf_delay_line #(.WIDTH(CW), .DEPTH(DEPTH)) u_dl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (in_valid_i),
    .din_i   (dl_din),
    .dout_o  (dl_dout)
  );

  assign head_re = dl_dout[CW-1:DATA_W];
  assign head_im = dl_dout[DATA_W-1:0];

  sdf_butterfly #(.DATA_W(DATA_W), .MODIFIED(MODIFIED)) u_bf (
    .a_re_i   (head_re),
    .a_im_i   (head_im),
    .b_re_i   (in_re_i),
    .b_im_i   (in_im_i),
    .rot_i    (rot_zone),
    .sum_re_o (s_re),
    .sum_im_o (s_im),
    .dif_re_o (d_re),
    .dif_im_o (d_im),
    .sat_o    (sat)
  );

  assign calc   = (phase == PH_CALC);
  assign dl_din = calc ? {d_re, d_im} : {in_re_i, in_im_i};
  assign nxt_re = calc ? s_re : head_re;
  assign nxt_im = calc ? s_im : head_im;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_re_o    <= '0;
      out_im_o    <= '0;
    end else begin
      out_valid_o <= in_valid_i & (calc | primed);
      if (in_valid_i) begin
        out_re_o <= nxt_re;
        out_im_o <= nxt_im;
      end
    end
  end

  p_valid_needs_accept_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> $past(in_valid_i));
  p_idle_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> (!out_valid_o && $stable(out_re_o) && $stable(out_im_o)));
  // (a+b)/2 + (a-b)/2 recombines to a, plus at most one LSB of rounding
  p_recombine_re_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && calc && !sat) |->
      ((DATA_W+2)'(s_re) + (DATA_W+2)'(d_re) - (DATA_W+2)'(head_re)) inside {0, 1});
  p_recombine_im_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && calc && !sat) |->
      ((DATA_W+2)'(s_im) + (DATA_W+2)'(d_im) - (DATA_W+2)'(head_im)) inside {0, 1});
endmodule

// File: tb/tb_sdf_r2_stage.sv
`timescale 1ns/1ps
module tb_sdf_r2_stage;
  localparam int DW = 16;
  localparam int NV = 18;
  // in_re, in_im, exp_valid, exp_re, exp_im  (DEPTH=2, MODIFIED=1)
  localparam int VEC [NV][5] = '{
    '{100, 50, 0, 0, 0},
    '{-30, 7, 0, 0, 0},
    '{20, -10, 1, 60, 20},
    '{5, 5, 1, -12, 6},
    '{11, 3, 1, 40, 30},
    '{-8, -9, 1, -17, 1},
    '{40, 6, 1, 9, -18},
    '{1, -2, 1, -5, -5},
    '{32767, -32768, 1, 3, 22},
    '{0, 0, 1, -3, -4},
    '{-32768, 32767, 1, 0, 0},
    '{0, 0, 1, 0, 0},
    '{0, 0, 1, 32767, -32767},
    '{0, 32767, 1, 0, 0},
    '{0, -32768, 1, -16384, 0},
    '{-32768, 0, 1, 0, 32767},
    '{0, 0, 1, 16384, 0},
    '{0, 0, 1, 0, 0}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic in_valid;
  logic signed [DW-1:0] in_re, in_im;
  logic out_valid;
  logic signed [DW-1:0] out_re, out_im;

  sdf_r2_stage #(.DATA_W(DW), .DEPTH(2), .MODIFIED(1'b1)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid), .in_re_i(in_re), .in_im_i(in_im),
    .out_valid_o(out_valid), .out_re_o(out_re), .out_im_o(out_im)
  );

  // 16-point chain
  logic c_in_v;
  logic signed [DW-1:0] c_in_re, c_in_im;
  logic v1, v2, v3, v4;
  logic signed [DW-1:0] r1, i1, r2, i2, r3, i3, r4, i4, tr, ti;

  sdf_r2_stage #(.DATA_W(DW), .DEPTH(8), .MODIFIED(1'b0)) u_c1 (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(c_in_v), .in_re_i(c_in_re), .in_im_i(c_in_im),
    .out_valid_o(v1), .out_re_o(r1), .out_im_o(i1));
  sdf_r2_stage #(.DATA_W(DW), .DEPTH(4), .MODIFIED(1'b1)) u_c2 (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(v1), .in_re_i(r1), .in_im_i(i1),
    .out_valid_o(v2), .out_re_o(r2), .out_im_o(i2));
  sdf_r2_stage #(.DATA_W(DW), .DEPTH(2), .MODIFIED(1'b0)) u_c3 (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(v2), .in_re_i(tr), .in_im_i(ti),
    .out_valid_o(v3), .out_re_o(r3), .out_im_o(i3));
  sdf_r2_stage #(.DATA_W(DW), .DEPTH(1), .MODIFIED(1'b1)) u_c4 (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(v3), .in_re_i(r3), .in_im_i(i3),
    .out_valid_o(v4), .out_re_o(r4), .out_im_o(i4));

  int tw_re [16];
  int tw_im [16];
  logic [3:0] tw_pos;

  initial begin
    for (int e = 0; e < 16; e++) begin
      real c, s;
      c = 16384.0 * $cos(2.0 * 3.14159265358979 * e / 16.0);
      s = -16384.0 * $sin(2.0 * 3.14159265358979 * e / 16.0);
      tw_re[e] = $rtoi(c >= 0.0 ? c + 0.5 : c - 0.5);
      tw_im[e] = $rtoi(s >= 0.0 ? s + 0.5 : s - 0.5);
    end
  end

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) tw_pos <= '0;
    else if (v2) tw_pos <= tw_pos + 4'd1;
  end

  // twiddle W16^(n3 * bitrev2(q)) between the stage pairs
  always_comb begin
    int e, pr, pi;
    e  = int'(tw_pos[1:0]) * int'({tw_pos[2], tw_pos[3]});
    pr = int'(r2) * tw_re[e] - int'(i2) * tw_im[e];
    pi = int'(r2) * tw_im[e] + int'(i2) * tw_re[e];
    tr = DW'((pr + 8192) >>> 14);
    ti = DW'((pi + 8192) >>> 14);
  end

  int col_re [64];
  int col_im [64];
  int ncol = 0;
  always @(negedge clk) begin
    if (rst_ni && v4 && ncol < 64) begin
      col_re[ncol] = int'(r4);
      col_im[ncol] = int'(i4);
      ncol = ncol + 1;
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    in_valid = 1'b0; in_re = '0; in_im = '0;
    c_in_v = 1'b0; c_in_re = '0; c_in_im = '0;
    @(negedge clk); rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic walk(input bit gaps);
    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      in_valid = 1'b1; in_re = DW'(VEC[k][0]); in_im = DW'(VEC[k][1]);
      @(negedge clk);
      in_valid = 1'b0;
      check(k >= 2 ? "R6" : "R1", $sformatf("valid k=%0d", k), int'(out_valid), VEC[k][2]);
      check(k == 14 || k == 15 ? "R5" : (k >= 12 ? "R4" : (k % 4 >= 2 ? "R2" : "R3")),
            $sformatf("re k=%0d", k), int'(out_re), VEC[k][3]);
      check(k == 15 ? "R5" : (k == 12 ? "R4" : (k % 4 >= 2 ? "R2" : "R3")),
            $sformatf("im k=%0d", k), int'(out_im), VEC[k][4]);
      if (gaps) begin
        @(negedge clk);
        check("R6", $sformatf("idle valid k=%0d", k), int'(out_valid), 0);
        check("R6", $sformatf("idle re k=%0d", k), int'(out_re), VEC[k][3]);
        check("R6", $sformatf("idle im k=%0d", k), int'(out_im), VEC[k][4]);
      end
    end
  endtask

  int xr [64];
  int xi [64];

  task automatic run_chain();
    int seed, n;
    seed = 12345;
    n = 0;
    for (int s = 0; s < 64; s++) begin
      if (s < 48) begin
        seed = seed * 1103515245 + 12345;
        xr[s] = ((seed >>> 8) % 4000);
        seed = seed * 1103515245 + 12345;
        xi[s] = ((seed >>> 8) % 4000);
      end else begin
        xr[s] = 0; xi[s] = 0;
      end
      @(negedge clk);
      c_in_v = 1'b1; c_in_re = DW'(xr[s]); c_in_im = DW'(xi[s]);
      if (s % 5 == 4) begin
        @(negedge clk);
        c_in_v = 1'b0;
      end
      n++;
    end
    @(negedge clk);
    c_in_v = 1'b0;
    repeat (8) @(negedge clk);
    check("R8", "output count", ncol >= 48 ? 1 : 0, 1);
    for (int f = 0; f < 3; f++) begin
      for (int p = 0; p < 16; p++) begin
        int k;
        real er, ei;
        k = {p[0], p[1], p[2], p[3]};
        er = 0.0; ei = 0.0;
        for (int m = 0; m < 16; m++) begin
          real ang;
          ang = 2.0 * 3.14159265358979 * k * m / 16.0;
          er += xr[16*f+m] * $cos(ang) + xi[16*f+m] * $sin(ang);
          ei += xi[16*f+m] * $cos(ang) - xr[16*f+m] * $sin(ang);
        end
        er = er / 16.0; ei = ei / 16.0;
        checks++;
        if ((col_re[16*f+p] - er) > 2.0 || (er - col_re[16*f+p]) > 2.0 ||
            (col_im[16*f+p] - ei) > 2.0 || (ei - col_im[16*f+p]) > 2.0) begin
          errors++;
          $display("FAIL R8 frame %0d pos %0d actual %0d,%0d expected %0d,%0d",
                   f, p, col_re[16*f+p], col_im[16*f+p], $rtoi(er), $rtoi(ei));
        end
      end
    end
  endtask

  initial begin
    do_reset();
    @(negedge clk);
    check("R7", "reset valid", int'(out_valid), 0);
    check("R7", "reset re", int'(out_re), 0);
    check("R7", "reset im", int'(out_im), 0);
    walk(1'b0);
    do_reset();
    @(negedge clk);
    check("R7", "re-reset valid", int'(out_valid), 0);
    walk(1'b1);
    do_reset();
    run_chain();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule